// File: doc/BRIEF.md
# Text-Mode Cell Blitter

This engine edits a text-mode screen buffer in which every cell is a 16-bit word. The character code sits in the high byte and the colour attribute in the low byte. A host loads the command fields and pulses a start strobe. The engine then walks a rectangle of cells and does one of three jobs through a single-port cell memory interface:

- It moves a rectangle to another position.
- It fills a rectangle with one character.
- It writes a stream of character codes, taken from a small input FIFO, into the rectangle in reading order.

The copy picks its walking direction from the relative positions of source and destination, so an overlapping move gives the same result as a move through a temporary buffer. Cell addresses are computed from a column stride and a row stride. The column stride is a power of two, and the row stride is derived from the virtual screen width in pixels. The engine signals completion with a one-cycle done pulse and holds a busy level while it owns the memory port.

Top module: `txt_blit`

## Requirements
- R1: For copy (cmd 0), the walk goes forward when the source row is greater than the destination row, or when the rows are equal and the source column is greater. Forward means first row first, columns increasing within each row. In every other case the walk starts at the last cell (bottom right) and goes backward. The final buffer equals a copy made through a temporary buffer.
- R2: Copy writes each source cell's full 16 bits to its destination unchanged. Each destination write is preceded by a read of its source cell.
- R3: Fill and write store the attribute byte {bg_i[3:0], fg_i[3:0]} in cell bits 7:0. The character goes in bits 15:8. The upper nibbles of fg_i and bg_i are ignored.
- R4: Fill (cmd 1) writes fill_idx_i and the attribute to every cell of the destination rectangle, in forward order.
- R5: Write (cmd 2) pops codes from the FIFO in arrival order. It places them in forward order over the destination rectangle, and it stops after code_len_i writes even in the middle of a row.
- R6: A cell at column c and row r is at address (c + r*(vwidth_px_i/8)) << shift_i.
- R7: While mem_req_o is high and mem_ack_i is low, the address, write enable and write data hold steady. A write takes effect on the cycle it is acknowledged.
- R8: A start pulse is taken only when the engine is idle. A start while busy has no effect on the running command.
- R9: busy_o rises the cycle after an accepted start and falls on the cycle after the last write is acknowledged. done_o pulses high for one cycle at that point, and no request follows.
- R10: A width or height of zero, a write command with code_len_i zero, or the reserved cmd 3 raises done_o the cycle after start. In these cases busy_o stays low and no memory request is made.
- R11: After reset, busy_o, done_o and mem_req_o are low and code_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| cmd_i | input | 2 | 0 copy, 1 fill, 2 write, 3 reserved |
| src_col_i | input | COL_W | Source column |
| src_row_i | input | ROW_W | Source row |
| dst_col_i | input | COL_W | Destination column |
| dst_row_i | input | ROW_W | Destination row |
| width_i | input | COL_W | Rectangle width in cells |
| height_i | input | ROW_W | Rectangle height in cells |
| fg_i | input | 8 | Foreground colour (low nibble used) |
| bg_i | input | 8 | Background colour (low nibble used) |
| fill_idx_i | input | 8 | Fill character |
| code_len_i | input | LEN_W | Number of codes for write |
| shift_i | input | SH_W | Column stride exponent |
| vwidth_px_i | input | VW_W | Virtual screen width in pixels |
| code_valid_i | input | 1 | Code FIFO push valid |
| code_data_i | input | 8 | Code FIFO push data |
| code_ready_o | output | 1 | Code FIFO not full |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory cell address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs overlapping copies in all four relative directions: right, left, down and up. A design that walked the wrong way would overwrite source cells before reading them, and both the scoreboard and the final buffer compare against a copy through a temporary buffer would show it. A write command whose count ends mid-row checks that the engine stops on the count and not on the row edge; an engine that ignored the count would touch the cell after the last code. Zero-sized and reserved commands must finish with no request, and a start during a fill must not change its cells. Attribute masking of the upper colour nibbles and a column stride of two cover the address and packing rules.

// File: rtl/txt_blit_pkg.sv
package txt_blit_pkg;
  typedef enum logic [1:0] {
    CMD_COPY  = 2'd0,
    CMD_FILL  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_RSVD  = 2'd3
  } blit_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } blit_st_e;

  function automatic logic [7:0] pack_attr(input logic [7:0] fg, input logic [7:0] bg);
    return {bg[3:0], fg[3:0]};
  endfunction
endpackage

// File: rtl/txt_blit_fifo.sv
module txt_blit_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [DW-1:0] head_o
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end
endmodule

// File: rtl/txt_blit_walk.sv
module txt_blit_walk #(
  parameter int COL_W = 8,
  parameter int ROW_W = 8,
  parameter int AW    = 16,
  parameter int VW_W  = 12,
  parameter int SH_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             fwd_i,
  input  logic             step_i,
  input  logic [COL_W-1:0] width_i,
  input  logic [ROW_W-1:0] height_i,
  input  logic [COL_W-1:0] src_col_i,
  input  logic [ROW_W-1:0] src_row_i,
  input  logic [COL_W-1:0] dst_col_i,
  input  logic [ROW_W-1:0] dst_row_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [VW_W-1:0]  vwidth_i,
  output logic [AW-1:0]    src_addr_o,
  output logic [AW-1:0]    dst_addr_o,
  output logic             last_o
);
  localparam int CPR_W = VW_W - 3;

  logic [COL_W-1:0] w_q, col_q, sc_q, dc_q;
  logic [ROW_W-1:0] h_q, row_q, sr_q, dr_q;
  logic [SH_W-1:0]  sh_q;
  logic [CPR_W-1:0] cpr_q;
  logic             fwd_q;

  function automatic logic [AW-1:0] cell_addr(input logic [COL_W:0] c, input logic [ROW_W:0] r);
    logic [AW-1:0] lin;
    lin = AW'(c) + AW'(r) * AW'(cpr_q);
    return lin << sh_q;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q <= '0; h_q <= '0; col_q <= '0; row_q <= '0;
      sc_q <= '0; sr_q <= '0; dc_q <= '0; dr_q <= '0;
      sh_q <= '0; cpr_q <= '0; fwd_q <= 1'b1;
    end else if (load_i) begin
      w_q   <= width_i;
      h_q   <= height_i;
      sc_q  <= src_col_i;
      sr_q  <= src_row_i;
      dc_q  <= dst_col_i;
      dr_q  <= dst_row_i;
      sh_q  <= shift_i;
      cpr_q <= vwidth_i[VW_W-1:3];
      fwd_q <= fwd_i;
      col_q <= fwd_i ? '0 : width_i - 1'b1;
      row_q <= fwd_i ? '0 : height_i - 1'b1;
    end else if (step_i) begin
      if (fwd_q) begin
        if (col_q == w_q - 1'b1) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end else begin
        if (col_q == '0) begin
          col_q <= w_q - 1'b1;
          row_q <= row_q - 1'b1;
        end else begin
          col_q <= col_q - 1'b1;
        end
      end
    end
  end

  assign last_o = fwd_q ? (col_q == w_q - 1'b1 && row_q == h_q - 1'b1)
                        : (col_q == '0 && row_q == '0);
  assign src_addr_o = cell_addr({1'b0, sc_q} + {1'b0, col_q}, {1'b0, sr_q} + {1'b0, row_q});
  assign dst_addr_o = cell_addr({1'b0, dc_q} + {1'b0, col_q}, {1'b0, dr_q} + {1'b0, row_q});
endmodule

// File: rtl/txt_blit.sv
module txt_blit
  import txt_blit_pkg::*;
#(
  parameter int COL_W      = 8,
  parameter int ROW_W      = 8,
  parameter int AW         = 16,
  parameter int LEN_W      = 16,
  parameter int VW_W       = 12,
  parameter int SH_W       = 2,
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       cmd_i,
  input  logic [COL_W-1:0] src_col_i,
  input  logic [ROW_W-1:0] src_row_i,
  input  logic [COL_W-1:0] dst_col_i,
  input  logic [ROW_W-1:0] dst_row_i,
  input  logic [COL_W-1:0] width_i,
  input  logic [ROW_W-1:0] height_i,
  input  logic [7:0]       fg_i,
  input  logic [7:0]       bg_i,
  input  logic [7:0]       fill_idx_i,
  input  logic [LEN_W-1:0] code_len_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [VW_W-1:0]  vwidth_px_i,
  input  logic             code_valid_i,
  input  logic [7:0]       code_data_i,
  output logic             code_ready_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [15:0]      mem_wdata_o,
  input  logic [15:0]      mem_rdata_i,
  input  logic             mem_ack_i,
  output logic             busy_o,
  output logic             done_o
);
  blit_st_e         state_q;
  blit_cmd_e        cmd_q;
  logic [7:0]       attr_q, fill_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [15:0]      cell_q;
  logic             done_q;

  logic             accept, zero_job, fwd_sel, wr_done, last_cell, step;
  logic             fifo_full, fifo_empty, fifo_pop;
  logic [7:0]       fifo_head;
  logic [AW-1:0]    src_addr, dst_addr;
  logic             walk_last;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign zero_job = (width_i == '0) || (height_i == '0) || (cmd_i == CMD_RSVD) ||
                    ((cmd_i == CMD_WRITE) && (code_len_i == '0));
  // overlap-safe direction: forward only when source lies after destination
  assign fwd_sel  = (cmd_i != CMD_COPY) || (src_row_i > dst_row_i) ||
                    ((src_row_i == dst_row_i) && (src_col_i > dst_col_i));

  txt_blit_walk #(
    .COL_W(COL_W), .ROW_W(ROW_W), .AW(AW), .VW_W(VW_W), .SH_W(SH_W)
  ) i_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && !zero_job),
    .fwd_i      (fwd_sel),
    .step_i     (step),
    .width_i    (width_i),
    .height_i   (height_i),
    .src_col_i  (src_col_i),
    .src_row_i  (src_row_i),
    .dst_col_i  (dst_col_i),
    .dst_row_i  (dst_row_i),
    .shift_i    (shift_i),
    .vwidth_i   (vwidth_px_i),
    .src_addr_o (src_addr),
    .dst_addr_o (dst_addr),
    .last_o     (walk_last)
  );

  txt_blit_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (code_valid_i),
    .data_i  (code_data_i),
    .pop_i   (fifo_pop),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .head_o  (fifo_head)
  );

  assign code_ready_o = !fifo_full;

  always_comb begin
    mem_req_o   = (state_q == ST_READ) ||
                  ((state_q == ST_WRITE) && ((cmd_q != CMD_WRITE) || !fifo_empty));
    mem_we_o    = (state_q == ST_WRITE);
    mem_addr_o  = (state_q == ST_READ) ? src_addr : dst_addr;
    mem_wdata_o = (cmd_q == CMD_COPY)  ? cell_q :
                  (cmd_q == CMD_WRITE) ? {fifo_head, attr_q} : {fill_q, attr_q};
  end

  assign wr_done   = (state_q == ST_WRITE) && mem_req_o && mem_ack_i;
  assign last_cell = walk_last || ((cmd_q == CMD_WRITE) && (cnt_q == len_q - 1'b1));
  assign step      = wr_done && !last_cell;
  assign fifo_pop  = wr_done && (cmd_q == CMD_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_COPY;
      attr_q  <= '0;
      fill_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      cell_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          cmd_q  <= blit_cmd_e'(cmd_i);
          attr_q <= pack_attr(fg_i, bg_i);
          fill_q <= fill_idx_i;
          len_q  <= code_len_i;
          cnt_q  <= '0;
          if (zero_job)                  done_q  <= 1'b1;
          else if (cmd_i == CMD_COPY)    state_q <= ST_READ;
          else                           state_q <= ST_WRITE;
        end
        ST_READ: if (mem_ack_i) begin
          cell_q  <= mem_rdata_i;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (wr_done) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_cell) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (cmd_q == CMD_COPY) begin
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/txt_blit_chk.sv
module txt_blit_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    cmd_i,
  input logic [7:0]    fg_i,
  input logic [7:0]    bg_i,
  input logic [7:0]    fill_idx_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [15:0]   mem_wdata_o
);
  logic [1:0] c_cmd;
  logic [7:0] c_attr, c_fill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_cmd  <= '0;
      c_attr <= '0;
      c_fill <= '0;
    end else if (start_i && !busy_o) begin
      c_cmd  <= cmd_i;
      c_attr <= {bg_i[3:0], fg_i[3:0]};
      c_fill <= fill_idx_i;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
    $stable(mem_we_o) && $stable(mem_wdata_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R10

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9

  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R8

  AST_ATTR_PACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && (c_cmd != 2'd0) |-> mem_wdata_o[7:0] == c_attr); // R3

  AST_FILL_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && (c_cmd == 2'd1) |-> mem_wdata_o[15:8] == c_fill); // R4
endmodule

bind txt_blit txt_blit_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_txt_blit.sv
module test_txt_blit;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = '0;
  logic [7:0]  sc = '0, dc = '0, w = '0;
  logic [7:0]  sr = '0, dr = '0, h = '0;
  logic [7:0]  fg = '0, bg = '0, fidx = '0, code_d = '0;
  logic [15:0] len = '0;
  logic [1:0]  sh = '0;
  logic [11:0] vw = 12'd320;
  logic        code_v = 1'b0, code_rdy;
  logic        req, we, ack, busy, done;
  logic [AW-1:0] addr;
  logic [15:0] wdata, rdata;

  logic [15:0] mem  [0:4095];
  logic [15:0] snap [0:4095];
  logic [15:0] exp_a[$], exp_d[$];
  int checks = 0, errors = 0, req_cycles = 0;

  always #4 clk = ~clk;

  txt_blit i_txt_blit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd),
    .src_col_i(sc), .src_row_i(sr), .dst_col_i(dc), .dst_row_i(dr),
    .width_i(w), .height_i(h), .fg_i(fg), .bg_i(bg), .fill_idx_i(fidx),
    .code_len_i(len), .shift_i(sh), .vwidth_px_i(vw),
    .code_valid_i(code_v), .code_data_i(code_d), .code_ready_o(code_rdy),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ack_i(ack), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= req && !ack;
      if (req && !ack) begin
        if (we) mem[addr[11:0]] <= wdata;
        else    rdata <= mem[addr[11:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && req) req_cycles++;
    if (rst_n && req && we && ack) begin
      if (exp_a.size() == 0) begin
        chk(1'b0, "R1 unexpected write", int'(addr), 0);
      end else begin
        logic [15:0] ea, ed;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        chk(addr == ea, "R6 write address", int'(addr), int'(ea));
        chk(wdata == ed, "R2 write data", int'(wdata), int'(ed));
      end
    end
  end

  function automatic int caddr(input int c, input int r);
    return (c + r * (int'(vw) / 8)) << sh;
  endfunction

  task automatic take_snap();
    for (int i = 0; i < 4096; i++) snap[i] = mem[i];
  endtask

  task automatic go(input bit zero);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (zero) begin
      chk(done == 1'b1 && busy == 1'b0, "R10 immediate done", {done, busy}, 2'b10);
    end else begin
      chk(busy == 1'b1, "R9 busy after start", busy, 1);
      while (!done) @(negedge clk);
      chk(busy == 1'b0, "R9 busy low at done", busy, 0);
      chk(exp_a.size() == 0, "R1 all writes seen", exp_a.size(), 0);
    end
  endtask

  task automatic run_copy(input int scol, input int srow, input int dcol, input int drow,
                          input int wd, input int ht);
    bit fwd;
    int bad;
    cmd = 2'd0; sc = 8'(scol); sr = 8'(srow); dc = 8'(dcol); dr = 8'(drow);
    w = 8'(wd); h = 8'(ht);
    take_snap();
    fwd = (srow > drow) || (srow == drow && scol > dcol);
    for (int k = 0; k < wd * ht; k++) begin
      int r, c;
      r = fwd ? k / wd : ht - 1 - k / wd;
      c = fwd ? k % wd : wd - 1 - k % wd;
      exp_a.push_back(16'(caddr(dcol + c, drow + r)));
      exp_d.push_back(snap[caddr(scol + c, srow + r)]);
    end
    go(1'b0);
    // memmove reference over the whole buffer
    bad = 0;
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] e;
      e = snap[i];
      for (int r = 0; r < ht; r++)
        for (int c = 0; c < wd; c++)
          if (caddr(dcol + c, drow + r) == i) e = snap[caddr(scol + c, srow + r)];
      if (mem[i] !== e) bad++;
    end
    chk(bad == 0, "R1 overlap result equals memmove", bad, 0);
  endtask

  task automatic push_code(input logic [7:0] d);
    @(negedge clk);
    code_v = 1'b1; code_d = d;
    @(negedge clk);
    code_v = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 40503) ^ 16'h5a5a;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && req == 0 && code_rdy == 1, "R11 reset state",
        {busy, done, req, code_rdy}, 4'b0001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_copy(2, 3, 4, 3, 5, 2);     // right overlap, backward R1 R2
    run_copy(6, 5, 3, 5, 5, 2);     // left overlap, forward R1
    run_copy(1, 8, 2, 10, 4, 4);    // down overlap, backward R1
    run_copy(10, 14, 9, 12, 4, 4);  // up overlap, forward R1

    // fill with stride 2 and masked colour nibbles: R3 R4 R6
    sh = 2'd1; cmd = 2'd1; dc = 8'd10; dr = 8'd5; w = 8'd3; h = 8'd2;
    fg = 8'hFA; bg = 8'h53; fidx = 8'hC4;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 3; c++) begin
        exp_a.push_back(16'(caddr(10 + c, 5 + r)));
        exp_d.push_back(16'hC43A);
      end
    go(1'b0);
    chk(mem[caddr(12, 6)] == 16'hC43A, "R4 last fill cell", mem[caddr(12, 6)], 16'hC43A);
    sh = 2'd0;

    // write command ending mid-row: R5
    for (int i = 0; i < 7; i++) push_code(8'(8'h41 + i));
    take_snap();
    cmd = 2'd2; dc = 8'd0; dr = 8'd18; w = 8'd3; h = 8'd4; len = 16'd7;
    fg = 8'h02; bg = 8'h01;
    for (int i = 0; i < 7; i++) begin
      exp_a.push_back(16'(caddr(i % 3, 18 + i / 3)));
      exp_d.push_back({8'(8'h41 + i), 8'h12});
    end
    go(1'b0);
    chk(mem[caddr(1, 20)] == snap[caddr(1, 20)], "R5 stop mid-row", mem[caddr(1, 20)],
        snap[caddr(1, 20)]);
    chk(mem[caddr(0, 20)] == 16'h4712, "R5 last code placed", mem[caddr(0, 20)], 16'h4712);

    // zero-sized and reserved commands: R10
    begin
      int rc;
      rc = req_cycles;
      cmd = 2'd1; w = 8'd0; h = 8'd3; go(1'b1);
      cmd = 2'd0; w = 8'd3; h = 8'd0; go(1'b1);
      cmd = 2'd3; w = 8'd2; h = 8'd2; go(1'b1);
      cmd = 2'd2; len = 16'd0; go(1'b1);
      repeat (3) @(negedge clk);
      chk(req_cycles == rc, "R10 no memory access", req_cycles - rc, 0);
    end

    // start while busy ignored: R8
    cmd = 2'd1; dc = 8'd20; dr = 8'd1; w = 8'd4; h = 8'd2; fg = 8'h07; bg = 8'h00; fidx = 8'h2E;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++) begin
        exp_a.push_back(16'(caddr(20 + c, 1 + r)));
        exp_d.push_back(16'h2E07);
      end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    fidx = 8'h99; dc = 8'd0; cmd = 2'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    begin
      int rc;
      rc = req_cycles;
      repeat (6) @(negedge clk);
      chk(req_cycles == rc && !busy, "R8 second start ignored", req_cycles - rc, 0);
    end
    chk(exp_a.size() == 0, "R8 fill complete", exp_a.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule